// File: doc/BRIEF.md
# Unsigned Restoring Array Divider

This block divides one unsigned operand by another in a single combinational pass. The first operand is the dividend and the second is the divisor. It returns the integer quotient and the remainder. The logic is fully unrolled into one row per quotient bit. Each row works on a partial remainder: the remainder left by the row above, shifted up one place, with the next dividend bit brought in below it. The row subtracts the divisor through a chain of one-bit borrow cells. The borrow that leaves the most significant cell shows whether the difference went negative.

A small steering unit per row turns that borrow into two strobes. The first tells the row's multiplexer to keep the partial remainder unchanged (restore) instead of taking the difference. The second is the quotient bit, which is set when no restore is needed. Rows run from the most significant dividend bit down to the least significant one. The last row's output is the remainder.

The block has no clock. It suits a datapath that can afford a deep combinational path, or one that places registers around it. A zero divisor gives a defined result with no extra logic: the quotient is all ones and the remainder equals the dividend.

Top module: `div_array`

## Requirements
- R1: For a nonzero divisor, `quotient` equals the integer part of `dividend / divisor`, both operands taken as unsigned.
- R2: For a nonzero divisor, `remainder` equals `dividend` modulo `divisor`.
- R3: For a nonzero divisor, `remainder` is strictly less than `divisor`, and `quotient * divisor + remainder` equals `dividend`.
- R4: When `divisor` is zero, `quotient` has every bit set to 1.
- R5: When `divisor` is zero, `remainder` equals `dividend`.
- R6: When `dividend` is less than a nonzero `divisor`, `quotient` is 0 and `remainder` equals `dividend`.
- R7: When `divisor` is 1, `quotient` equals `dividend` and `remainder` is 0.
- R8: When `dividend` equals a nonzero `divisor`, `quotient` is 1 and `remainder` is 0.
- R9: Both outputs are purely combinational. They hold the result for the operands currently applied, with no clock cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dividend | input | WIDTH | Unsigned number to be divided |
| divisor | input | WIDTH | Unsigned number to divide by |
| quotient | output | WIDTH | Integer quotient; all ones for a zero divisor |
| remainder | output | WIDTH | Remainder; equals the dividend for a zero divisor |

## Verification
Both results are due in the same cycle as their operands, because no register lies between the ports. The bench drives a new operand pair on a rising clock edge and reads both outputs at the following falling edge, half a period later, so every ripple chain has settled before sampling. At a width of four, the bench sweeps every operand pair, including every zero-divisor case. At a width of eight, it applies the named corner cases and then a few thousand random pairs. Each expected value comes from the bench's own integer division and modulo.

// File: rtl/divarr_pkg.sv
package divarr_pkg;
  // Strobes sent from a row's steering unit to its datapath.
  typedef struct packed {
    logic restore;  // keep the partial remainder, discard the difference
    logic quoBit;   // quotient bit produced by this row
  } rowStrobe_t;
endpackage

// File: rtl/div_sub_cell.sv
module div_sub_cell (
  input  logic minuendBit,
  input  logic subtrahendBit,
  input  logic borrowIn,
  output logic diffBit,
  output logic borrowOut
);
  logic halfDiff;

  always_comb begin
    halfDiff  = minuendBit ^ subtrahendBit;
    diffBit   = halfDiff ^ borrowIn;
    borrowOut = (~minuendBit & subtrahendBit) | (~halfDiff & borrowIn);
  end
endmodule

// File: rtl/div_row_steer.sv
module div_row_steer
  import divarr_pkg::*;
(
  input  logic       signBorrow,
  output rowStrobe_t strobe
);
  always_comb begin
    strobe.restore = signBorrow;
    strobe.quoBit  = ~signBorrow;
  end
endmodule

// File: rtl/div_row.sv
module div_row
  import divarr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] remIn,
  input  logic             dividendBit,
  input  logic [WIDTH-1:0] divisor,
  input  rowStrobe_t       strobe,
  output logic             signBorrow,
  output logic [WIDTH-1:0] remOut
);
  localparam int CELLS = WIDTH + 1;

  logic [CELLS-1:0] partial;
  logic [CELLS-1:0] subtrahend;
  logic [CELLS-1:0] diffVec;
  logic [CELLS:0]   borrowChain;

  assign partial        = {remIn, dividendBit};
  assign subtrahend     = {1'b0, divisor};
  assign borrowChain[0] = 1'b0;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    div_sub_cell u_cell (
      .minuendBit   (partial[c]),
      .subtrahendBit(subtrahend[c]),
      .borrowIn     (borrowChain[c]),
      .diffBit      (diffVec[c]),
      .borrowOut    (borrowChain[c+1])
    );
  end

  assign signBorrow = borrowChain[CELLS];

  always_comb begin
    remOut = strobe.restore ? partial[WIDTH-1:0] : diffVec[WIDTH-1:0];
  end

  always_comb begin
    // R3
    row_diff_fits_chk: assert (strobe.restore || !diffVec[WIDTH])
      else $error("row difference overflowed the remainder width");
    // R3
    row_partial_fits_chk: assert (!strobe.restore || !partial[WIDTH])
      else $error("restored partial remainder overflowed the width");
  end
endmodule

// File: rtl/div_array.sv
module div_array
  import divarr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int ROWS = WIDTH;
  localparam int PW   = 2 * WIDTH;

  logic [WIDTH-1:0] remChain [ROWS+1];
  logic             rowSign  [ROWS];
  rowStrobe_t       rowStb   [ROWS];

  assign remChain[0] = '0;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    div_row #(.WIDTH(WIDTH)) u_data (
      .remIn      (remChain[r]),
      .dividendBit(dividend[WIDTH-1-r]),
      .divisor    (divisor),
      .strobe     (rowStb[r]),
      .signBorrow (rowSign[r]),
      .remOut     (remChain[r+1])
    );
    div_row_steer u_ctl (
      .signBorrow(rowSign[r]),
      .strobe    (rowStb[r])
    );
    assign quotient[WIDTH-1-r] = rowStb[r].quoBit;
  end

  assign remainder = remChain[ROWS];

  logic [PW-1:0] rebuilt;
  always_comb begin
    rebuilt = PW'(quotient) * PW'(divisor) + PW'(remainder);
    // R3
    rem_below_divisor_chk: assert (divisor == '0 || remainder < divisor)
      else $error("remainder not below divisor");
    // R3
    identity_chk: assert (divisor == '0 || rebuilt == PW'(dividend))
      else $error("quotient*divisor+remainder differs from dividend");
    // R4
    zero_div_quo_chk: assert (divisor != '0 || quotient == '1)
      else $error("zero divisor quotient not all ones");
    // R5
    zero_div_rem_chk: assert (divisor != '0 || remainder == dividend)
      else $error("zero divisor remainder not equal to dividend");
  end
endmodule

// File: tb/tb_div_array.sv
`timescale 1ns/1ps
module tb_div_array;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] aWide, bWide, qWide, rWide;
  logic [3:0] aNar, bNar, qNar, rNar;

  int checks = 0;
  int errors = 0;

  div_array #(.WIDTH(8)) dut (
    .dividend(aWide), .divisor(bWide), .quotient(qWide), .remainder(rWide)
  );
  div_array #(.WIDTH(4)) dutSmall (
    .dividend(aNar), .divisor(bNar), .quotient(qNar), .remainder(rNar)
  );

  task automatic chk(input string req, input int act, input int exp, input int a, input int b);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d actual=%0d expected=%0d", req, a, b, act, exp);
    end
  endtask

  // Drive at a rising edge, sample half a period later (R9: no latency).
  task automatic apply8(input int a, input int b);
    @(posedge clk);
    aWide = 8'(a);
    bWide = 8'(b);
    @(negedge clk);
  endtask

  task automatic full8(input int a, input int b);
    apply8(a, b);
    if (b == 0) begin
      chk("R4", int'(qWide), 255, a, b);
      chk("R5", int'(rWide), a, a, b);
    end else begin
      chk("R1 R9", int'(qWide), a / b, a, b);
      chk("R2 R9", int'(rWide), a % b, a, b);
      chk("R3", int'(rWide < bWide), 1, a, b);
    end
  endtask

  task automatic mainFlow();
    aWide = '0; bWide = 8'd1; aNar = '0; bNar = 4'd1;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // Initial state: 0 / 1
    chk("R7 init", int'(qWide), 0, 0, 1);
    chk("R7 init", int'(rWide), 0, 0, 1);

    // Exhaustive sweep at width 4
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(posedge clk);
        aNar = 4'(a);
        bNar = 4'(b);
        @(negedge clk);
        if (b == 0) begin
          chk("R4", int'(qNar), 15, a, b);
          chk("R5", int'(rNar), a, a, b);
        end else begin
          chk("R1", int'(qNar), a / b, a, b);
          chk("R2", int'(rNar), a % b, a, b);
          chk("R3", int'(qNar) * b + int'(rNar), a, a, b);
        end
      end
    end

    // Corner cases at width 8
    apply8(37, 200);
    chk("R6", int'(qWide), 0, 37, 200);
    chk("R6", int'(rWide), 37, 37, 200);
    apply8(201, 1);
    chk("R7", int'(qWide), 201, 201, 1);
    chk("R7", int'(rWide), 0, 201, 1);
    apply8(173, 173);
    chk("R8", int'(qWide), 1, 173, 173);
    chk("R8", int'(rWide), 0, 173, 173);
    apply8(255, 0);
    chk("R4", int'(qWide), 255, 255, 0);
    chk("R5", int'(rWide), 255, 255, 0);
    full8(0, 0);
    full8(255, 255);
    full8(255, 2);
    full8(128, 3);
    full8(254, 127);

    // Random pairs at width 8
    for (int i = 0; i < 3000; i++) begin
      full8(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    end
  endtask

  initial begin
    fork
      mainFlow();
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule